// File: doc/BRIEF.md
# Byte Queue with Threshold-Driven DMA Requests

This block is a small synchronous byte queue that sits between a serial port's shift logic and the host side of a chip. One side pushes bytes and the other pops them. The queue reports its fill level, full and empty. From the fill level it derives a level interrupt and two DMA request lines, a single-transfer request and a burst request, for a DMA engine outside the block.

A 3-bit select picks a burst threshold as a fraction of the depth: one eighth, one quarter, one half, three quarters or seven eighths. A mode input set low makes the queue hold one byte only, so it behaves like a classic holding register. The meaning of the requests depends on a direction parameter. A receive queue asks to be emptied. A transmit queue asks to be filled.

Top module: `bq_dma_fifo`

## Requirements
- R1: While reset is asserted, and after its synchronised release, level is 0, empty is 1, full is 0 and overrun is 0.
- R2: With `fifo_en` high the queue holds up to DEPTH (16) bytes. Bytes leave in the order they were accepted. `pop_data` shows the oldest byte whenever the queue is not empty. `full` is 1 exactly when the level equals the capacity, and `empty` is 1 exactly when the level is 0.
- R3: A push while full is dropped and leaves the level and the contents unchanged. It sets `overrun`, which stays at 1 until reset.
- R4: A pop while empty is ignored, and the level stays 0.
- R5: A push and a pop in the same cycle, with the queue neither full nor empty, leave the level unchanged and move the data along. When the queue is empty only the push takes effect. When it is full only the pop takes effect.
- R6: `trig_sel` codes 0, 1, 2, 3 and 4 give thresholds of 2, 4, 8, 12 and 14 entries. Codes 5 to 7 give 8. The select is registered and applies from the clock edge after it is presented. Its reset value is code 2.
- R7: Receive direction (IS_TX=0): `dma_single` is 1 exactly when the level is at least 1.
- R8: Receive direction with `fifo_en` high: `dma_burst` and `lvl_irq` are 1 exactly when the level is greater than or equal to the threshold.
- R9: Transmit direction (IS_TX=1): `dma_single` is 1 exactly when the level is below the capacity. With `fifo_en` high, `dma_burst` and `lvl_irq` are 1 exactly when the level is less than or equal to the threshold.
- R10: With `fifo_en` low the capacity is one byte. `full` rises at level 1. The threshold is ignored, and `dma_burst` and `lvl_irq` equal `dma_single`.
- R11: `level` equals the number of bytes held, changing on the clock edge that accepts a push or a pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fifo_en | input | 1 | 1: full-depth queue, 0: one-byte holding register |
| trig_sel | input | 3 | Encoded burst threshold select |
| push | input | 1 | Write request |
| push_data | input | DATA_W | Byte to write |
| pop | input | 1 | Read request |
| pop_data | output | DATA_W | Oldest byte held |
| level | output | clog2(DEPTH+1) | Number of bytes held |
| full | output | 1 | Level equals capacity |
| empty | output | 1 | Level is zero |
| overrun | output | 1 | Sticky: a push was dropped |
| dma_single | output | 1 | Single-transfer DMA request |
| dma_burst | output | 1 | Burst DMA request |
| lvl_irq | output | 1 | Level interrupt |

## Verification
The bench walks every threshold code, including the three invalid ones, through a complete fill and drain. This shows up a comparator that is off by one or a decode that has been mirrored, because the burst line would then flip one entry early or late. It pushes into a full queue and pops from an empty one. A design that wrapped its pointers there would corrupt the byte order the scoreboard tracks, or move the level. Simultaneous push and pop is applied when the queue is empty, part full and full, where a naive count update drifts. One-byte mode is checked at levels 0 and 1 with the threshold set to its extremes. A design that still used the threshold there would show burst values that differ from the single request.

// File: rtl/bq_pkg.sv
package bq_pkg;

  typedef enum logic [2:0] {
    TRG_EIGHTH  = 3'd0,
    TRG_QUARTER = 3'd1,
    TRG_HALF    = 3'd2,
    TRG_3QUART  = 3'd3,
    TRG_7EIGHTH = 3'd4
  } trig_code_e;

  // Threshold in entries for a code; unknown codes fall back to one half.
  function automatic int unsigned trig_entries(input logic [2:0] code,
                                               input int unsigned depth);
    case (code)
      TRG_EIGHTH:  return depth / 8;
      TRG_QUARTER: return depth / 4;
      TRG_HALF:    return depth / 2;
      TRG_3QUART:  return (3 * depth) / 4;
      TRG_7EIGHTH: return (7 * depth) / 8;
      default:     return depth / 2;
    endcase
  endfunction

endpackage

// File: rtl/bq_trig.sv
module bq_trig
  import bq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       code_i,
  output logic [CNT_W-1:0] thr_o
);

  logic [2:0] code_q;
  logic [2:0] code_d;

  always_comb begin
    code_d = code_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) code_q <= TRG_HALF;
    else        code_q <= code_d;
  end

  always_comb begin
    thr_o = CNT_W'(trig_entries(code_q, DEPTH));
  end

  // R6: threshold is always a legal, non-trivial level
  p_thr_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_o != '0) && (int'(thr_o) < DEPTH));

  // R6: an undefined code lands on the half level
  p_bad_code_half_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (code_i > 3'd4) |=> (int'(thr_o) == DEPTH / 2));

endmodule

// File: rtl/bq_store.sv
module bq_store #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              one_deep,
  input  logic              push_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] data_o,
  output logic [CNT_W-1:0]  level_o,
  output logic              full_o,
  output logic              empty_o,
  output logic              ovr_o
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_q, wr_d, rd_q, rd_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d, cap;
  logic              ovr_q, ovr_d;
  logic              push_ok, pop_ok;

  always_comb begin
    cap     = one_deep ? CNT_W'(1) : CNT_W'(DEPTH);
    full_o  = (cnt_q >= cap);
    empty_o = (cnt_q == '0);
    push_ok = push_i && !full_o;
    pop_ok  = pop_i && !empty_o;
  end

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    ovr_d = ovr_q;
    if (push_ok) wr_d = (wr_q == PTR_LAST) ? '0 : wr_q + 1'b1;
    if (pop_ok)  rd_d = (rd_q == PTR_LAST) ? '0 : rd_q + 1'b1;
    if (push_ok && !pop_ok)      cnt_d = cnt_q + 1'b1;
    else if (pop_ok && !push_ok) cnt_d = cnt_q - 1'b1;
    if (push_i && full_o) ovr_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      ovr_q <= 1'b0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
      ovr_q <= ovr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_q] <= data_i;
  end

  always_comb begin
    data_o  = mem[rd_q];
    level_o = cnt_q;
    ovr_o   = ovr_q;
  end

  // R2: the count never passes the storage depth
  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    int'(level_o) <= DEPTH);

  // R3: a lone push into a full queue changes nothing but the flag
  p_full_push_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (full_o && push_i && !pop_i) |=> ($stable(level_o) && ovr_o));

  // R3: overrun is sticky
  p_ovr_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_o |=> ovr_o);

  // R4: a lone pop on an empty queue keeps it empty
  p_empty_pop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (empty_o && pop_i && !push_i) |=> (level_o == '0));

  // R5: balanced traffic keeps the level
  p_pushpop_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && pop_i && !full_o && !empty_o) |=> $stable(level_o));

  // R10: one-byte mode never holds more than one byte once drained
  p_one_deep_cap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (one_deep && empty_o) |=> (int'(level_o) <= 1));

endmodule

// File: rtl/bq_dma_fifo.sv
module bq_dma_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  parameter bit IS_TX  = 1'b0
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       fifo_en,
  input  logic [2:0]                 trig_sel,
  input  logic                       push,
  input  logic [DATA_W-1:0]          push_data,
  input  logic                       pop,
  output logic [DATA_W-1:0]          pop_data,
  output logic [$clog2(DEPTH+1)-1:0] level,
  output logic                       full,
  output logic                       empty,
  output logic                       overrun,
  output logic                       dma_single,
  output logic                       dma_burst,
  output logic                       lvl_irq
);

  localparam int CNT_W = $clog2(DEPTH + 1);

  logic             rst_meta, rst_s_n;
  logic [CNT_W-1:0] thr;
  logic             single_c, fifo_hit;

  // Asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s_n  <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s_n  <= rst_meta;
    end
  end

  bq_trig #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_trig (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .code_i (trig_sel),
    .thr_o  (thr)
  );

  bq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .one_deep (!fifo_en),
    .push_i   (push),
    .data_i   (push_data),
    .pop_i    (pop),
    .data_o   (pop_data),
    .level_o  (level),
    .full_o   (full),
    .empty_o  (empty),
    .ovr_o    (overrun)
  );

  generate
    if (IS_TX) begin : g_tx
      always_comb begin
        single_c = !full;
        fifo_hit = (level <= thr);
      end
      // R9: a full transmit queue never asks for data
      p_tx_full_quiet_r9: assert property (@(posedge clk) disable iff (!rst_s_n)
        full |-> !dma_single);
    end else begin : g_rx
      always_comb begin
        single_c = !empty;
        fifo_hit = (level >= thr);
      end
      // R8: an empty receive queue never asks for a burst
      p_rx_empty_quiet_r8: assert property (@(posedge clk) disable iff (!rst_s_n)
        empty |-> !dma_burst);
    end
  endgenerate

  always_comb begin
    dma_single = single_c;
    dma_burst  = fifo_en ? fifo_hit : single_c;
    lvl_irq    = dma_burst;
  end

  // R8/R9/R10: a burst request always comes with a single request
  p_burst_has_single_r10: assert property (@(posedge clk) disable iff (!rst_s_n)
    dma_burst |-> dma_single);

endmodule

// File: tb/tb_bq_dma_fifo.sv
`timescale 1ns/1ps
module tb_bq_dma_fifo;

  localparam int DW  = 8;
  localparam int DEP = 16;
  localparam int CW  = $clog2(DEP + 1);

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n, fifo_en, push, pop;
  logic [2:0]    trig_sel;
  logic [DW-1:0] push_data;
  logic [DW-1:0] rx_data, tx_data;
  logic [CW-1:0] rx_lvl, tx_lvl;
  logic rx_full, rx_empty, rx_ovr, rx_single, rx_burst, rx_irq;
  logic tx_full, tx_empty, tx_ovr, tx_single, tx_burst, tx_irq;

  bq_dma_fifo #(.DATA_W(DW), .DEPTH(DEP), .IS_TX(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .trig_sel(trig_sel),
    .push(push), .push_data(push_data), .pop(pop), .pop_data(rx_data),
    .level(rx_lvl), .full(rx_full), .empty(rx_empty), .overrun(rx_ovr),
    .dma_single(rx_single), .dma_burst(rx_burst), .lvl_irq(rx_irq));

  bq_dma_fifo #(.DATA_W(DW), .DEPTH(DEP), .IS_TX(1'b1)) dut_tx (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .trig_sel(trig_sel),
    .push(push), .push_data(push_data), .pop(pop), .pop_data(tx_data),
    .level(tx_lvl), .full(tx_full), .empty(tx_empty), .overrun(tx_ovr),
    .dma_single(tx_single), .dma_burst(tx_burst), .lvl_irq(tx_irq));

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  logic [DW-1:0] sb[$];
  int m_lvl = 0;
  bit m_ovr = 1'b0;

  function automatic int thr_of(input logic [2:0] c);
    case (c)
      3'd0: return 2;
      3'd1: return 4;
      3'd2: return 8;
      3'd3: return 12;
      3'd4: return 14;
      default: return 8;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic check_all();
    int cap, thr;
    cap = fifo_en ? DEP : 1;
    thr = thr_of(trig_sel);
    chk("R11 rx level", 32'(rx_lvl), m_lvl);
    chk("R11 tx level", 32'(tx_lvl), m_lvl);
    chk("R2 empty", 32'(rx_empty), m_lvl == 0);
    chk("R2 full", 32'(rx_full), m_lvl >= cap);
    chk("R3 overrun", 32'(rx_ovr), m_ovr);
    chk("R7 rx single", 32'(rx_single), m_lvl > 0);
    chk("R9 tx single", 32'(tx_single), m_lvl < cap);
    if (fifo_en) begin
      chk("R8 rx burst", 32'(rx_burst), m_lvl >= thr);
      chk("R8 rx irq", 32'(rx_irq), m_lvl >= thr);
      chk("R9 tx burst", 32'(tx_burst), m_lvl <= thr);
      chk("R9 tx irq", 32'(tx_irq), m_lvl <= thr);
    end else begin
      chk("R10 rx burst", 32'(rx_burst), m_lvl > 0);
      chk("R10 rx irq", 32'(rx_irq), m_lvl > 0);
      chk("R10 tx burst", 32'(tx_burst), m_lvl < cap);
      chk("R10 tx irq", 32'(tx_irq), m_lvl < cap);
    end
  endtask

  // Driver plus scoreboard: predicts acceptance, queues expected bytes,
  // compares the head byte when a pop is accepted.
  task automatic cyc(input bit p, input logic [DW-1:0] d, input bit o);
    int cap;
    bit pok, ook;
    cap = fifo_en ? DEP : 1;
    pok = p && (m_lvl < cap);
    ook = o && (m_lvl > 0);
    push = p; push_data = d; pop = o;
    if (ook) begin
      chk("R2 rx order", 32'(rx_data), 32'(sb[0]));
      chk("R2 tx order", 32'(tx_data), 32'(sb[0]));
      void'(sb.pop_front());
    end
    if (pok) sb.push_back(d);
    if (p && !pok) m_ovr = 1'b1;
    m_lvl = m_lvl + int'(pok) - int'(ook);
    @(posedge clk); #1;
    push = 1'b0; pop = 1'b0;
    check_all();
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    rst_n = 1'b0; fifo_en = 1'b1; trig_sel = 3'd2;
    push = 1'b0; pop = 1'b0; push_data = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 level in reset", 32'(rx_lvl), 0);
    chk("R1 empty in reset", 32'(rx_empty), 1);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 full after reset", 32'(rx_full), 0);
    chk("R1 overrun after reset", 32'(rx_ovr), 0);
    check_all();

    // R6 and R8/R9: every threshold code through a full fill and drain
    for (int c = 0; c < 8; c++) begin
      trig_sel = 3'(c);
      for (int i = 0; i < DEP; i++) cyc(1'b1, 8'(c * 16 + i + 1), 1'b0);
      if (c == 0) begin
        cyc(1'b1, 8'hEE, 1'b0);           // R3: dropped push
        chk("R3 level kept", 32'(rx_lvl), DEP);
        chk("R3 overrun set", 32'(rx_ovr), 1);
      end
      for (int i = 0; i < DEP; i++) cyc(1'b0, 8'h00, 1'b1);
      if (c == 0) begin
        cyc(1'b0, 8'h00, 1'b1);           // R4: ignored pop
        chk("R4 level stays zero", 32'(rx_lvl), 0);
        chk("R4 still empty", 32'(rx_empty), 1);
      end
    end

    // R5: simultaneous push and pop in each region
    trig_sel = 3'd1;
    cyc(1'b1, 8'hA5, 1'b1);               // empty: push only
    chk("R5 empty push wins", 32'(rx_lvl), 1);
    for (int i = 0; i < 4; i++) cyc(1'b1, 8'(8'h30 + i), 1'b0);
    for (int i = 0; i < 3; i++) cyc(1'b1, 8'(8'h40 + i), 1'b1);
    chk("R5 balanced level", 32'(rx_lvl), 5);
    for (int i = 0; i < 11; i++) cyc(1'b1, 8'(8'h50 + i), 1'b0);
    cyc(1'b1, 8'h77, 1'b1);               // full: pop only
    chk("R5 full pop wins", 32'(rx_lvl), DEP - 1);
    while (m_lvl > 0) cyc(1'b0, 8'h00, 1'b1);

    // R10: one-byte holding mode with extreme thresholds
    fifo_en = 1'b0;
    trig_sel = 3'd0;
    cyc(1'b0, 8'h00, 1'b0);
    cyc(1'b1, 8'h11, 1'b0);
    chk("R10 full at one", 32'(rx_full), 1);
    chk("R10 rx burst ignores threshold", 32'(rx_burst), 1);
    cyc(1'b1, 8'h22, 1'b0);               // dropped
    chk("R10 capacity one", 32'(rx_lvl), 1);
    trig_sel = 3'd4;
    cyc(1'b0, 8'h00, 1'b0);
    chk("R10 tx burst ignores threshold", 32'(tx_burst), 0);
    cyc(1'b0, 8'h00, 1'b1);
    cyc(1'b1, 8'h33, 1'b1);
    cyc(1'b0, 8'h00, 1'b1);
    chk("R10 drained", 32'(rx_empty), 1);

    summary();
  end

endmodule